// File: doc/BRIEF.md
# Register dump sequencer

This block carries out a register dump command. A start pulse latches the dump base address, which is the sum of a base input and a 32-bit offset field, and the address where the status word goes. The sequencer then pushes one command byte into the outbound transmit FIFO. It drains the inbound status FIFO until the echoed marker byte comes back from the MAC side, and throws away anything that arrives ahead of the marker.

Once the marker has arrived, the bytes that follow are packed little-endian into 32-bit words. The sequencer writes them to memory at ascending addresses. It then writes the words of a locally held parallel register bus, so the dump area holds 596 bytes in total. Last comes one status word marking the command as complete and error-free. A single-cycle done pulse follows the acceptance of that status write.

Top module: `regdump_seq`

## Requirements
- R1: A start pulse while idle causes exactly one write of the command byte (default 8'h06) to the transmit FIFO. The write is withheld for as long as `txf_full` is high.
- R2: The status FIFO is read only while `stf_empty` is low. Bytes popped before the marker (default 8'hD5) are discarded, and no memory write happens before the marker has been popped.
- R3: The 580 bytes popped after the marker are written as 32-bit words to consecutive addresses `cu_base + dump_offset + 4*n`. The first byte of each group of four goes in bits 7:0 and the fourth in bits 31:24.
- R4: After the streamed words, the PAR_WORDS (default 4) words of `par_regs` are written at the following addresses. Byte i of that region is `par_regs[8i+7:8i]`, so the dump holds exactly 596 bytes.
- R5: An empty status FIFO stalls the byte packing without losing position. While `mem_ready` is low, `mem_wr`, `mem_addr` and `mem_data` are held. At most one of `txf_wr`, `stf_rd` and `mem_wr` is high in any cycle.
- R6: After the last dump word, exactly one write of 32'h0000A000 goes to `cb_addr`. In that word, bit 15 is the completion flag and bit 13 is the no-error flag.
- R7: `done` is high for exactly one cycle, in the cycle after the status write is accepted.
- R8: A start pulse while a dump is in progress is ignored.
- R9: After reset, `txf_wr`, `stf_rd`, `mem_wr` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start the dump command |
| cu_base | input | 32 | Base address added to the offset |
| dump_offset | input | 32 | Offset field of the command |
| cb_addr | input | 32 | Address of the status word |
| par_regs | input | 128 | Parallel registers, byte i at bits 8i+7:8i |
| txf_full | input | 1 | Transmit FIFO full |
| txf_wr | output | 1 | Transmit FIFO write strobe |
| txf_data | output | 8 | Transmit FIFO write byte |
| stf_empty | input | 1 | Status FIFO empty |
| stf_data | input | 8 | Status FIFO head byte |
| stf_rd | output | 1 | Status FIFO pop |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 32 | Memory write word |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- the FIFO handshake rules;
- that no memory write comes before the marker is popped;
- that the strobes are mutually exclusive and held across memory stalls;
- that done is a single cycle following an accepted status write.

Only the bench scenarios can show the content and order of the 596 dumped bytes. The same goes for the discarding of junk bytes, the single status write landing after the last word, and a busy-time start being ignored. The bench covers each of these under several combinations of FIFO gaps, memory stalls and transmit back-pressure.

// File: rtl/regdump_seq.sv
module regdump_seq #(
  parameter int DUMP_BYTES = 596,
  parameter int PAR_WORDS = 4,
  parameter int ADDR_W = 32,
  parameter logic [7:0] CMD_BYTE = 8'h06,
  parameter logic [7:0] MARKER = 8'hD5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [ADDR_W-1:0]      cu_base,
  input  logic [ADDR_W-1:0]      dump_offset,
  input  logic [ADDR_W-1:0]      cb_addr,
  input  logic [PAR_WORDS*32-1:0] par_regs,
  input  logic                   txf_full,
  output logic                   txf_wr,
  output logic [7:0]             txf_data,
  input  logic                   stf_empty,
  input  logic [7:0]             stf_data,
  output logic                   stf_rd,
  output logic                   mem_wr,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [31:0]            mem_data,
  input  logic                   mem_ready,
  output logic                   done
);
  localparam int TOTAL_WORDS = DUMP_BYTES / 4;
  localparam int STREAM_WORDS = TOTAL_WORDS - PAR_WORDS;
  localparam int WCW = $clog2(TOTAL_WORDS + 1);
  localparam logic [31:0] STATUS_OK = 32'h0000_A000;

  typedef enum logic [2:0] {IDLE, CMD, SYNC, FILL, WSTR, WPAR, WSTAT} st_t;
  st_t st;

  logic [ADDR_W-1:0] base, stat_a;
  logic [WCW-1:0]    wcnt, pidx;
  logic [1:0]        bcnt;
  logic [31:0]       wbuf, par_word;

  assign txf_wr   = (st == CMD) && !txf_full;
  assign txf_data = CMD_BYTE;
  assign stf_rd   = ((st == SYNC) || (st == FILL)) && !stf_empty;
  assign mem_wr   = (st == WSTR) || (st == WPAR) || (st == WSTAT);
  assign pidx     = wcnt - WCW'(STREAM_WORDS);

  always_comb begin
    par_word = '0;
    for (int i = 0; i < PAR_WORDS; i++)
      if (pidx == WCW'(i)) par_word = par_regs[i*32 +: 32];
  end

  assign mem_data = (st == WSTAT) ? STATUS_OK : (st == WPAR) ? par_word : wbuf;
  assign mem_addr = (st == WSTAT) ? stat_a : base + (ADDR_W'(wcnt) << 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      base <= '0;
      stat_a <= '0;
      wcnt <= '0;
      bcnt <= '0;
      wbuf <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          base <= cu_base + dump_offset;
          stat_a <= cb_addr;
          wcnt <= '0;
          bcnt <= '0;
          st <= CMD;
        end
        CMD: if (!txf_full) st <= SYNC;
        SYNC: if (stf_rd && stf_data == MARKER) st <= FILL;
        FILL: if (stf_rd) begin
          wbuf[{bcnt, 3'b000} +: 8] <= stf_data;
          bcnt <= bcnt + 2'd1;
          if (bcnt == 2'd3) st <= WSTR;
        end
        WSTR: if (mem_ready) begin
          wcnt <= wcnt + 1'b1;
          st <= (wcnt == WCW'(STREAM_WORDS - 1)) ? WPAR : FILL;
        end
        WPAR: if (mem_ready) begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WCW'(TOTAL_WORDS - 1)) st <= WSTAT;
        end
        WSTAT: if (mem_ready) begin
          st <= IDLE;
          done <= 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regdump_seq_chk.sv
module regdump_seq_chk #(
  parameter int ADDR_W = 32,
  parameter logic [7:0] MARKER = 8'hD5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txf_wr,
  input logic              txf_full,
  input logic              stf_rd,
  input logic              stf_empty,
  input logic [7:0]        stf_data,
  input logic              mem_wr,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_data,
  input logic              done
);
  logic mk_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) mk_seen <= 1'b0;
    else if (done) mk_seen <= 1'b0;
    else if (stf_rd && stf_data == MARKER) mk_seen <= 1'b1;
  end

  // R1
  txf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) txf_wr |-> !txf_full);
  // R2
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) stf_rd |-> !stf_empty);
  // R2
  early_wr_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> mk_seen);
  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_data)));
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({txf_wr, stf_rd, mem_wr}));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_wr && mem_ready && mem_data == 32'h0000_A000));
endmodule

bind regdump_seq regdump_seq_chk #(.ADDR_W(ADDR_W), .MARKER(MARKER)) u_chk (
  .clk(clk), .rst_n(rst_n), .txf_wr(txf_wr), .txf_full(txf_full),
  .stf_rd(stf_rd), .stf_empty(stf_empty), .stf_data(stf_data),
  .mem_wr(mem_wr), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_data(mem_data), .done(done)
);

// File: tb/sim_regdump_seq.sv
`timescale 1ns/1ps
module sim_regdump_seq;
  localparam int NB = 596;
  localparam int NW = NB / 4;
  localparam int NPAR = 16;
  localparam logic [7:0] MK = 8'hD5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] cu_base = '0, dump_offset = '0, cb_addr = '0;
  logic [127:0] par_regs = '0;
  logic txf_full = 1'b0, stf_empty = 1'b1, mem_ready = 1'b0;
  logic [7:0] stf_data = '0;
  logic txf_wr, stf_rd, mem_wr, done;
  logic [7:0] txf_data;
  logic [31:0] mem_addr, mem_data;

  int tests = 0, fails = 0;
  always #2 clk = ~clk;

  regdump_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cu_base(cu_base),
    .dump_offset(dump_offset), .cb_addr(cb_addr), .par_regs(par_regs),
    .txf_full(txf_full), .txf_wr(txf_wr), .txf_data(txf_data),
    .stf_empty(stf_empty), .stf_data(stf_data), .stf_rd(stf_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] img [NB];
  logic [7:0] expb [NB];

  task automatic run_case(input int k);
    logic [7:0] q [$];
    int gap_mod, rdy_mod, fullc, cmd_n, cmd_c, wbm, nwr, nstat, stat_idx, stat_c;
    int done_n, done_c, addr_bad, c;
    logic [7:0] cmd_v;
    logic [31:0] stat_v, base;
    bit mk_pop;
    gap_mod = (k == 1) ? 3 : (k == 2) ? 2 : (k == 3) ? 5 : 0;
    rdy_mod = (k == 1) ? 4 : (k == 3) ? 2 : 0;
    fullc = k * 3;
    cu_base = 32'h1000_0000 + k * 32'h100;
    dump_offset = 32'h0000_2000 + k * 32'h40;
    base = cu_base + dump_offset;
    cb_addr = base - 32'd64;
    for (int i = 0; i < NPAR; i++) par_regs[i*8 +: 8] = 8'(i * 11 + k + 8'h40);
    for (int j = 0; j <= k; j++) q.push_back(8'(8'h10 + j));
    q.push_back(MK);
    for (int i = 0; i < NB - NPAR; i++) begin
      expb[i] = 8'(i * 7 + k * 29 + 3);
      q.push_back(expb[i]);
    end
    for (int i = 0; i < NPAR; i++) expb[NB - NPAR + i] = par_regs[i*8 +: 8];
    for (int i = 0; i < NB; i++) img[i] = 8'hxx;
    cmd_n = 0; cmd_c = -1; wbm = 0; nwr = 0; nstat = 0; stat_idx = -1; stat_c = -1;
    done_n = 0; done_c = -1; addr_bad = 0; mk_pop = 0; cmd_v = 0; stat_v = 0;
    c = 0;
    while (c < 6000 && !(done_c >= 0 && c > done_c + 8)) begin
      @(negedge clk);
      start = (c == 0) || (c == 200);
      txf_full = (c < fullc);
      stf_empty = (q.size() == 0) || (gap_mod != 0 && c % gap_mod == 0);
      stf_data = (q.size() != 0) ? q[0] : 8'h00;
      mem_ready = !(rdy_mod != 0 && c % rdy_mod == 1);
      #1;
      if (txf_wr && !txf_full) begin cmd_n++; cmd_v = txf_data; if (cmd_c < 0) cmd_c = c; end
      if (stf_rd && !stf_empty) begin
        if (q[0] == MK) mk_pop = 1;
        void'(q.pop_front());
      end
      if (mem_wr && mem_ready) begin
        if (!mk_pop) wbm++;
        if (mem_addr == cb_addr) begin
          nstat++; stat_v = mem_data; stat_idx = nwr; stat_c = c;
        end else begin
          if (mem_addr != base + 32'(nwr * 4)) addr_bad++;
          else for (int b = 0; b < 4; b++) img[nwr*4 + b] = mem_data[b*8 +: 8];
          nwr++;
        end
      end
      if (done) begin done_n++; done_c = c; end
      c++;
    end
    start = 1'b0;
    chk(done_c >= 0, "R7 watchdog run", done_c, 0);
    chk(cmd_n == 1 && cmd_v == 8'h06, "R1 R8 single command byte", cmd_v, 8'h06);
    chk(cmd_c >= fullc, "R1 write held while full", cmd_c, fullc);
    chk(wbm == 0, "R2 no write before marker", wbm, 0);
    chk(addr_bad == 0 && nwr == NW, "R3 R4 R8 ascending word count", nwr, NW);
    for (int i = 0; i < NB; i += 4) begin
      logic [31:0] a, e;
      a = {img[i+3], img[i+2], img[i+1], img[i]};
      e = {expb[i+3], expb[i+2], expb[i+1], expb[i]};
      if (i < NB - NPAR) chk(a === e, "R2 R3 R5 streamed word", a, e);
      else chk(a === e, "R4 parallel word", a, e);
    end
    chk(nstat == 1 && stat_v == 32'h0000_A000, "R6 status word", stat_v, 32'h0000_A000);
    chk(stat_idx == NW, "R6 status after last word", stat_idx, NW);
    chk(done_n == 1, "R7 done pulse count", done_n, 1);
    chk(done_c == stat_c + 1, "R7 done timing", done_c, stat_c + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!txf_wr && !stf_rd && !mem_wr && !done, "R9 reset outputs",
        {txf_wr, stf_rd, mem_wr, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!txf_wr && !stf_rd && !mem_wr && !done, "R9 idle after reset",
        {txf_wr, stf_rd, mem_wr, done}, 0);
    for (int k = 0; k < 4; k++) run_case(k);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule